// File: doc/BRIEF.md
# Multi-Rail Power-Up Sequencer

This block is a clocked controller that brings up a set of supply rails in a fixed order. It watches comparator flags for the input supply and for the undervoltage-lockout level of each rail. From these flags it drives enables for one core rail, two I/O rails and four secondary rails. It first gives the core rail a timed soft-start window. It then turns on both I/O rails together. Once all three primary rails report good, it runs a power-on-reset delay. When that delay expires it raises a power-on-sense flag and releases the secondary rails.

A power-good flag combines power-on-sense with a second, higher input-supply threshold. Synchronous inhibit bits, written by a register file elsewhere, keep any secondary rail off. The two adjustable linear rails additionally require the 5 V rail to be on. Every comparator flag passes through a synchronizer before the control logic uses it. Losing the input supply drops everything back to idle. Losing a primary rail withdraws power-on-sense and the secondary rails, and the reset delay starts again from zero.

Top module: `rail_power_sequencer`

## Requirements
- R1: After reset every enable output, `por_sense` and `pwr_good` are low, and they stay low while the synchronized `vin_sd_ok` is low.
- R2: The I/O enables stay low for exactly `SS_TICKS` cycles after `en_core` rises. They rise at the end of that window only if the core lockout flag is set, and `en_io33` implies `en_core`.
- R3: `en_io33` and `en_io25` always switch together.
- R4: `por_sense` rises `POR_TICKS + 1` cycles after the I/O enables rise, provided all three primary flags are already good. It is never high without the I/O enables.
- R5: On the rise of `por_sense`, all non-inhibited secondary enables rise in the same cycle. No secondary enable is ever high without `por_sense`.
- R6: The bits of `inhibit` map as follows: bit 0 is linear rail 1, bit 1 is linear rail 2, bit 2 is the 5 V rail and bit 3 is the motor rail. A set bit forces its enable low in the same cycle.
- R7: `en_lin1` and `en_lin2` are low whenever `en_5v` is low.
- R8: `pwr_good` equals `por_sense` AND the synchronized `vin_good_ok`. A change on `vin_good_ok` reaches `pwr_good` on the second rising edge.
- R9: When `vin_sd_ok` falls, all outputs clear on the third rising edge, and the sequencer restarts from idle.
- R10: If any primary lockout flag drops during the reset wait or after `por_sense` is set, `por_sense` and the secondary enables clear while the primary enables stay on. The reset delay then restarts from zero.
- R11: A change on a comparator flag reaches the state-driven outputs on the third rising edge: two synchronizer stages plus the state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vin_sd_ok | input | 1 | Input supply above its shutdown threshold |
| vin_good_ok | input | 1 | Input supply above its higher lockout threshold |
| core_uv_ok | input | 1 | Core rail above lockout |
| io33_uv_ok | input | 1 | 3.3 V rail above lockout |
| io25_uv_ok | input | 1 | 2.5 V rail above lockout |
| inhibit | input | 4 | Per-rail secondary disable bits (synchronous) |
| en_core | output | 1 | Core rail enable |
| en_io33 | output | 1 | 3.3 V rail enable |
| en_io25 | output | 1 | 2.5 V rail enable |
| en_lin1 | output | 1 | Adjustable linear rail 1 enable |
| en_lin2 | output | 1 | Adjustable linear rail 2 enable |
| en_5v | output | 1 | 5 V rail enable |
| en_motor | output | 1 | Motor rail enable |
| por_sense | output | 1 | Power-on-sense flag |
| pwr_good | output | 1 | Power-good flag |

## Verification
A flag edge driven between clock edges reaches the state-driven enables and `por_sense` on the third rising edge. It reaches `pwr_good` on the second, and `inhibit` acts in the same cycle. The soft-start window lasts `SS_TICKS` cycles, and the reset wait adds `POR_TICKS + 1` after the I/O enables rise. The bench advances a behavioural model at every rising edge and compares all outputs at the following falling edge. Directed checks count falling edges from each stimulus to confirm those exact latencies, including a one-cycle flag glitch that must restart the full reset delay.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_CORE_SS  = 3'd1,
      ST_IO_UP    = 3'd2,
      ST_POR_WAIT = 3'd3,
      ST_RUN      = 3'd4
   } seq_state_t;

   // comparator flag positions in the synchronized vector
   localparam int FLG_VIN_SD   = 0;
   localparam int FLG_VIN_GOOD = 1;
   localparam int FLG_CORE     = 2;
   localparam int FLG_IO33     = 3;
   localparam int FLG_IO25     = 4;
   localparam int NUM_FLAGS    = 5;

   // secondary rail positions (match the inhibit port)
   localparam int SEC_LIN1  = 0;
   localparam int SEC_LIN2  = 1;
   localparam int SEC_5V    = 2;
   localparam int SEC_MOTOR = 3;
   localparam int NUM_SEC   = 4;

endpackage

// File: rtl/rail_flag_sync.sv
module rail_flag_sync #(
   parameter int WIDTH  = 5,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rail_flag_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("rail_flag_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain[s] <= '0;
         end else begin
            if (s == 0) chain[s] <= d;
            else        chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rail_delay_timer.sv
module rail_delay_timer #(
   parameter int SS_TICKS  = 8,
   parameter int POR_TICKS = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic sel_por,
   output logic done
);
   if (SS_TICKS < 1 || POR_TICKS < 1) begin : g_bad_ticks
      $error("rail_delay_timer: tick counts must be at least 1");
   end

   localparam int MAXT = (SS_TICKS > POR_TICKS) ? SS_TICKS : POR_TICKS;
   localparam int CW   = (MAXT > 1) ? $clog2(MAXT) : 1;
   localparam logic [CW-1:0] LIM_SS  = CW'(SS_TICKS - 1);
   localparam logic [CW-1:0] LIM_POR = CW'(POR_TICKS - 1);

   logic [CW-1:0] cnt;
   logic [CW-1:0] limit;

   assign limit = sel_por ? LIM_POR : LIM_SS;
   assign done  = run && (cnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run) begin
         cnt <= '0;
      end else if (cnt != limit) begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/rail_sec_gate.sv
module rail_sec_gate
   import rail_seq_pkg::*;
#(
   parameter logic [NUM_SEC-1:0] NEEDS_5V = 4'b0011
) (
   input  logic               por_on,
   input  logic [NUM_SEC-1:0] inhibit,
   output logic [NUM_SEC-1:0] en
);
   if (NEEDS_5V[SEC_5V]) begin : g_bad_dep
      $error("rail_sec_gate: the 5 V rail cannot depend on itself");
   end

   logic [NUM_SEC-1:0] base;
   assign base = {NUM_SEC{por_on}} & ~inhibit;

   for (genvar i = 0; i < NUM_SEC; i++) begin : g_rail
      if (NEEDS_5V[i]) begin : g_dep
         assign en[i] = base[i] & base[SEC_5V];
      end else begin : g_free
         assign en[i] = base[i];
      end
   end
endmodule

// File: rtl/rail_power_sequencer.sv
module rail_power_sequencer
   import rail_seq_pkg::*;
#(
   parameter int SS_TICKS    = 8,
   parameter int POR_TICKS   = 20,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       vin_sd_ok,
   input  logic       vin_good_ok,
   input  logic       core_uv_ok,
   input  logic       io33_uv_ok,
   input  logic       io25_uv_ok,
   input  logic [3:0] inhibit,
   output logic       en_core,
   output logic       en_io33,
   output logic       en_io25,
   output logic       en_lin1,
   output logic       en_lin2,
   output logic       en_5v,
   output logic       en_motor,
   output logic       por_sense,
   output logic       pwr_good
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("rail_power_sequencer: SYNC_STAGES must be at least 2");
   end

   logic [NUM_FLAGS-1:0] flags_raw;
   logic [NUM_FLAGS-1:0] flags_s;
   logic                 sd_ok, prim_ok, tmr_run, tmr_sel_por, tmr_done;
   logic [NUM_SEC-1:0]   sec_en;
   seq_state_t           state, state_nx;

   assign flags_raw[FLG_VIN_SD]   = vin_sd_ok;
   assign flags_raw[FLG_VIN_GOOD] = vin_good_ok;
   assign flags_raw[FLG_CORE]     = core_uv_ok;
   assign flags_raw[FLG_IO33]     = io33_uv_ok;
   assign flags_raw[FLG_IO25]     = io25_uv_ok;

   rail_flag_sync #(.WIDTH(NUM_FLAGS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (flags_raw),
      .q     (flags_s)
   );

   assign sd_ok   = flags_s[FLG_VIN_SD];
   assign prim_ok = flags_s[FLG_CORE] & flags_s[FLG_IO33] & flags_s[FLG_IO25];

   assign tmr_run     = (state == ST_CORE_SS) || (state == ST_POR_WAIT);
   assign tmr_sel_por = (state == ST_POR_WAIT);

   rail_delay_timer #(.SS_TICKS(SS_TICKS), .POR_TICKS(POR_TICKS)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (tmr_run),
      .sel_por (tmr_sel_por),
      .done    (tmr_done)
   );

   always_comb begin
      state_nx = state;
      if (!sd_ok) begin
         state_nx = ST_IDLE;
      end else begin
         unique case (state)
            ST_IDLE:     state_nx = ST_CORE_SS;
            ST_CORE_SS:  if (tmr_done && flags_s[FLG_CORE]) state_nx = ST_IO_UP;
            ST_IO_UP:    if (prim_ok) state_nx = ST_POR_WAIT;
            ST_POR_WAIT: begin
               if (!prim_ok)      state_nx = ST_IO_UP;
               else if (tmr_done) state_nx = ST_RUN;
            end
            ST_RUN:      if (!prim_ok) state_nx = ST_IO_UP;
            default:     state_nx = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_nx;
   end

   assign en_core   = (state != ST_IDLE);
   assign en_io33   = (state == ST_IO_UP) || (state == ST_POR_WAIT) || (state == ST_RUN);
   assign en_io25   = en_io33;
   assign por_sense = (state == ST_RUN);
   assign pwr_good  = por_sense & flags_s[FLG_VIN_GOOD];

   rail_sec_gate u_sec (
      .por_on  (por_sense),
      .inhibit (inhibit),
      .en      (sec_en)
   );

   assign en_lin1  = sec_en[SEC_LIN1];
   assign en_lin2  = sec_en[SEC_LIN2];
   assign en_5v    = sec_en[SEC_5V];
   assign en_motor = sec_en[SEC_MOTOR];
endmodule

// File: rtl/rail_power_sequencer_chk.sv
module rail_power_sequencer_chk #(
   parameter int SS_TICKS = 8
) (
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] inhibit,
   input logic       en_core,
   input logic       en_io33,
   input logic       en_io25,
   input logic       en_lin1,
   input logic       en_lin2,
   input logic       en_5v,
   input logic       en_motor,
   input logic       por_sense,
   input logic       pwr_good
);
   // cycles spent with core on and I/O still off
   int unsigned ss_seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    ss_seen <= 0;
      else if (!en_core)             ss_seen <= 0;
      else if (!en_io33 && ss_seen < 32'hFFFF_FFFF) ss_seen <= ss_seen + 1;
   end

   p_ss_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_io33) |-> ss_seen >= SS_TICKS);
   p_io_needs_core_r2: assert property (@(posedge clk) disable iff (!rst_n)
      en_io33 |-> en_core);
   p_io_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
      en_io33 == en_io25);
   p_por_needs_io_r4: assert property (@(posedge clk) disable iff (!rst_n)
      por_sense |-> en_io33);
   p_sec_needs_por_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en_lin1 | en_lin2 | en_5v | en_motor) |-> por_sense);
   p_inhibit_motor_r6: assert property (@(posedge clk) disable iff (!rst_n)
      inhibit[3] |-> !en_motor);
   p_inhibit_5v_r6: assert property (@(posedge clk) disable iff (!rst_n)
      inhibit[2] |-> !en_5v);
   p_lin_needs_5v_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en_lin1 | en_lin2) |-> en_5v);
   p_pg_needs_por_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_good |-> por_sense);
   p_por_secs_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(por_sense) && !inhibit[3]) |-> en_motor);
endmodule

bind rail_power_sequencer rail_power_sequencer_chk #(.SS_TICKS(SS_TICKS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .inhibit   (inhibit),
   .en_core   (en_core),
   .en_io33   (en_io33),
   .en_io25   (en_io25),
   .en_lin1   (en_lin1),
   .en_lin2   (en_lin2),
   .en_5v     (en_5v),
   .en_motor  (en_motor),
   .por_sense (por_sense),
   .pwr_good  (pwr_good)
);

// File: tb/rail_power_sequencer_bench.sv
`timescale 1ns/1ps
module rail_power_sequencer_bench;
   localparam int SS  = 8;
   localparam int POR = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic vin_sd_ok = 0, vin_good_ok = 0, core_uv_ok = 0, io33_uv_ok = 0, io25_uv_ok = 0;
   logic [3:0] inhibit = 4'b0000;
   logic en_core, en_io33, en_io25, en_lin1, en_lin2, en_5v, en_motor, por_sense, pwr_good;

   always #2.5 clk = ~clk;

   rail_power_sequencer #(.SS_TICKS(SS), .POR_TICKS(POR), .SYNC_STAGES(2)) u_rail_power_sequencer (
      .clk(clk), .rst_n(rst_n), .vin_sd_ok(vin_sd_ok), .vin_good_ok(vin_good_ok),
      .core_uv_ok(core_uv_ok), .io33_uv_ok(io33_uv_ok), .io25_uv_ok(io25_uv_ok),
      .inhibit(inhibit), .en_core(en_core), .en_io33(en_io33), .en_io25(en_io25),
      .en_lin1(en_lin1), .en_lin2(en_lin2), .en_5v(en_5v), .en_motor(en_motor),
      .por_sense(por_sense), .pwr_good(pwr_good));

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   // phase: 0 off, 1 core soft-start, 2 io on, 3 reset wait, 4 running
   int   m_phase = 0;
   int   m_ticks = 0;
   logic q1[5], q2[5];
   initial for (int i = 0; i < 5; i++) begin q1[i] = 0; q2[i] = 0; end

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_phase = 0; m_ticks = 0;
         for (int i = 0; i < 5; i++) begin q1[i] = 0; q2[i] = 0; end
      end else begin
         bit all_ok;
         all_ok = q2[2] && q2[3] && q2[4];
         if (!q2[0]) begin
            m_phase = 0; m_ticks = 0;
         end else if (m_phase == 0) begin
            m_phase = 1; m_ticks = 0;
         end else if (m_phase == 1) begin
            if (m_ticks >= SS - 1 && q2[2]) begin m_phase = 2; m_ticks = 0; end
            else if (m_ticks < SS - 1) m_ticks++;
         end else if (m_phase == 2) begin
            if (all_ok) begin m_phase = 3; m_ticks = 0; end
         end else if (m_phase == 3) begin
            if (!all_ok) begin m_phase = 2; m_ticks = 0; end
            else if (m_ticks >= POR - 1) begin m_phase = 4; m_ticks = 0; end
            else m_ticks++;
         end else begin
            if (!all_ok) m_phase = 2;
         end
         q2 = q1;
         q1[0] = vin_sd_ok; q1[1] = vin_good_ok; q1[2] = core_uv_ok;
         q1[3] = io33_uv_ok; q1[4] = io25_uv_ok;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         bit e_por, e5;
         logic [8:0] exp_v, act_v;
         e_por = (m_phase == 4);
         e5    = e_por && !inhibit[2];
         exp_v = {m_phase != 0, m_phase >= 2, m_phase >= 2, e_por,
                  e5 && !inhibit[0], e5 && !inhibit[1], e5,
                  e_por && !inhibit[3], e_por && q2[1]};
         act_v = {en_core, en_io33, en_io25, por_sense, en_lin1, en_lin2, en_5v, en_motor, pwr_good};
         checks++;
         if (exp_v !== act_v) begin
            errors++;
            $display("FAIL R1-model R2 R3 R4 R5 R8 outputs: actual %b expected %b (t=%0t)",
                     act_v, exp_v, $time);
         end
      end
   end

   // ---------------- watchdog ----------------
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !finished) begin
         finished = 1;
         errors++;
         $display("FAIL watchdog: actual %0d expected 0 cycles overrun", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic tick(); @(negedge clk); endtask

   // ---------------- directed sequence ----------------
   initial begin
      int n;
      repeat (4) tick();
      rst_n = 1'b1;
      tick();
      // R1: reset state
      chk({en_core, en_io33, por_sense, en_5v, en_motor, pwr_good} == 0, "R1 reset outputs", en_core, 0);
      core_uv_ok = 1; io33_uv_ok = 1; io25_uv_ok = 1; vin_good_ok = 1;
      repeat (5) tick();
      chk(en_core == 0, "R1 idle without supply", en_core, 0);

      // R11: synchronizer latency to the core enable
      vin_sd_ok = 1;
      tick(); tick();
      chk(en_core == 0, "R11 core enable before third edge", en_core, 0);
      tick();
      chk(en_core == 1, "R11 core enable on third edge", en_core, 1);

      // R2: soft-start window length
      n = 0;
      while (!en_io33 && n < 1000) begin tick(); n++; end
      chk(n == SS, "R2 soft-start cycles", n, SS);
      chk(en_io25 == en_io33, "R3 I/O pair together", en_io25, en_io33);

      // R4: reset delay
      n = 0;
      while (!por_sense && n < 1000) begin tick(); n++; end
      chk(n == POR + 1, "R4 reset wait cycles", n, POR + 1);
      chk({en_lin1, en_lin2, en_5v, en_motor} == 4'b1111, "R5 secondaries with por_sense",
          {en_lin1, en_lin2, en_5v, en_motor}, 15);
      chk(pwr_good == 1, "R8 power-good high", pwr_good, 1);

      // R6 / R7: inhibits act in the same cycle
      inhibit = 4'b1000;
      #1;
      chk(en_motor == 0 && en_5v == 1, "R6 motor inhibit", en_motor, 0);
      inhibit = 4'b0001;
      #1;
      chk(en_lin1 == 0 && en_lin2 == 1, "R6 linear 1 inhibit", en_lin1, 0);
      inhibit = 4'b0100;
      #1;
      chk(en_5v == 0 && en_lin1 == 0 && en_lin2 == 0, "R7 linear rails need 5 V",
          {en_lin1, en_lin2}, 0);
      tick();
      inhibit = 4'b0000;
      tick();

      // R8: vin_good path is two edges
      vin_good_ok = 0;
      tick();
      chk(pwr_good == 1, "R8 power-good holds one edge", pwr_good, 1);
      tick();
      chk(pwr_good == 0, "R8 power-good drops second edge", pwr_good, 0);
      chk(por_sense == 1, "R8 por_sense unaffected", por_sense, 1);
      vin_good_ok = 1;
      repeat (3) tick();

      // R10: primary drop while running
      io25_uv_ok = 0;
      repeat (3) tick();
      chk(por_sense == 0 && en_motor == 0, "R10 por_sense clears", por_sense, 0);
      chk(en_io33 == 1 && en_core == 1, "R10 primaries stay on", en_io33, 1);
      io25_uv_ok = 1;
      n = 0;
      while (!por_sense && n < 1000) begin tick(); n++; end
      chk(n == POR + 3, "R10 full delay after recovery", n, POR + 3);

      // R10: one-cycle glitch mid-wait restarts the timer from zero
      io25_uv_ok = 0;
      repeat (3) tick();
      io25_uv_ok = 1;
      repeat (6) tick();
      io25_uv_ok = 0;
      tick();
      io25_uv_ok = 1;
      n = 0;
      while (!por_sense && n < 1000) begin tick(); n++; end
      chk(n == POR + 3, "R10 glitch restarts delay", n, POR + 3);

      // R9: loss of input supply
      vin_sd_ok = 0;
      tick(); tick();
      chk(en_core == 1, "R9 outputs hold two edges", en_core, 1);
      tick();
      chk({en_core, en_io33, en_io25, por_sense, en_5v, en_motor, pwr_good} == 0,
          "R9 all outputs clear", en_core, 0);
      repeat (4) tick();
      chk(en_core == 0, "R9 stays idle", en_core, 0);

      // R9: restart from idle runs the full soft-start again
      vin_sd_ok = 1;
      repeat (3) tick();
      chk(en_core == 1 && en_io33 == 0, "R9 restart in soft-start", en_io33, 0);
      n = 0;
      while (!en_io33 && n < 1000) begin tick(); n++; end
      chk(n == SS, "R2 soft-start after restart", n, SS);

      // R2: core flag low holds the I/O rails off past the window
      vin_sd_ok = 0; core_uv_ok = 0;
      repeat (4) tick();
      vin_sd_ok = 1;
      repeat (SS + 10) tick();
      chk(en_core == 1 && en_io33 == 0, "R2 I/O waits for core flag", en_io33, 0);
      core_uv_ok = 1;
      repeat (3) tick();
      chk(en_io33 == 1, "R2 I/O after core flag", en_io33, 1);
      repeat (POR + 4) tick();

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule